// File: doc/BRIEF.md
# Interrupt Arbitration for a Three-Level Hart

This block keeps the pending-interrupt state of a hart that runs at user, supervisor and machine level. Each cycle it picks the one interrupt that may be taken right now. An interrupt is a candidate when its pending bit and its enable bit are both set. Whether a candidate may fire depends on two things: its delegation bit, which routes it to supervisor or to machine level, and how the current privilege compares with that target level. Among the candidates that may fire, the lowest-numbered one wins.

The pending register is written through a masked port. The value held before the write can be read on the same cycle as the write. A separate claim mask records which interrupt lines have been reserved by sources. A claim succeeds only if none of the requested lines is reserved already. A level request line reports that any interrupt at all is pending, whatever the enables say.

Top module: `irq_select`

## Requirements
- R1: While reset is high, and on the first cycle after it, the pending register, the claim mask, `irq_valid`, `irq_cause`, `irq_req` and `claim_done` are all zero.
- R2: A pending write with `pend_wr_en` high replaces only the bits selected by `pend_wr_mask` with the matching `pend_wr_data` bits, effective after the next clock edge. Bits 16 and above always read as zero, and a write with a zero mask changes nothing.
- R3: `pend_old` shows the pending register, so during the cycle of a write it returns the contents from before that write.
- R4: `irq_req` is high exactly when the pending register is nonzero, and falls after a write that clears every bit.
- R5: A candidate whose delegation bit is 0 may fire when the privilege is U (0), S (1) or the unused code 2, or when it is M (3) and `mie` is high.
- R6: A candidate whose delegation bit is 1 may fire when the privilege is U, or when it is S and `sie` is high. It never fires at M.
- R7: When several candidates may fire, `irq_cause` is the index of the least significant one.
- R8: When no candidate may fire, `irq_valid` is 0 and `irq_cause` is 0.
- R9: `irq_valid` and `irq_cause` are registered. They reflect the pending register and the other inputs as they were one clock edge earlier.
- R10: A claim (`claim_en`) fails if any requested bit below 16 is already in the claim mask, and then leaves the mask unchanged. Otherwise it ORs the requested bits below 16 into the mask. Request bits 16 and above are ignored. `claim_done` and `claim_ok` report the result one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend_wr_en | input | 1 | Pending register write strobe |
| pend_wr_mask | input | 32 | Bits to replace |
| pend_wr_data | input | 32 | Replacement values |
| pend_old | output | 32 | Current pending contents (pre-write value during a write) |
| enable_i | input | 32 | Interrupt enable bits |
| deleg_i | input | 32 | Delegation bits, 1 = supervisor target |
| priv_i | input | 2 | Current privilege: U=0, S=1, M=3 |
| mie_i | input | 1 | Machine global enable |
| sie_i | input | 1 | Supervisor global enable |
| claim_en | input | 1 | Claim request strobe |
| claim_bits | input | 32 | Lines requested by the claim |
| claim_mask | output | 32 | Lines claimed so far |
| claim_done | output | 1 | Claim result valid this cycle |
| claim_ok | output | 1 | Claim succeeded |
| irq_req | output | 1 | Any interrupt pending |
| irq_valid | output | 1 | An interrupt may be taken |
| irq_cause | output | 5 | Index of the chosen interrupt |

## Verification
A wrong pending bit shows up on `pend_old` and `irq_req` one cycle after the write that caused it. It shows up on `irq_valid` and `irq_cause` one cycle after that. A wrong gating term for delegation or privilege shows as a cause that fires, or stays silent, against the expected choice one edge after the privilege or enable change. A bad claim mask appears on `claim_mask` and in the next `claim_ok`. Each scenario is therefore compared on the edge where the change should first become visible.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

    typedef enum logic [1:0] {
        PRIV_U    = 2'd0,
        PRIV_S    = 2'd1,
        PRIV_RSVD = 2'd2,
        PRIV_M    = 2'd3
    } priv_e;

    // Lowest n bits set, for up to 64 lines.
    function automatic logic [63:0] low_ones(input int n);
        logic [63:0] r;
        r = '0;
        for (int i = 0; i < 64; i++) begin
            if (i < n) r[i] = 1'b1;
        end
        return r;
    endfunction

    // Non-delegated interrupts: target level is machine.
    function automatic logic mach_gate(input priv_e p, input logic mie);
        return (p < PRIV_M) || mie;
    endfunction

    // Delegated interrupts: target level is supervisor.
    function automatic logic sup_gate(input priv_e p, input logic sie);
        return (p < PRIV_S) || ((p == PRIV_S) && sie);
    endfunction

endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
    parameter int XLEN    = 32,
    parameter int NUM_IRQ = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_mask,
    input  logic [XLEN-1:0] wr_data,
    output logic [XLEN-1:0] pend_q
);
    import irq_sel_pkg::*;

    localparam logic [63:0]     ONES64 = low_ones(NUM_IRQ);
    localparam logic [XLEN-1:0] IMPL   = ONES64[XLEN-1:0];

    logic [XLEN-1:0] pend_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_r <= '0;
        end else if (wr_en) begin
            pend_r <= ((pend_r & ~wr_mask) | (wr_data & wr_mask)) & IMPL;
        end
    end

    assign pend_q = pend_r;
endmodule

// File: rtl/irq_claim_reg.sv
module irq_claim_reg #(
    parameter int XLEN    = 32,
    parameter int NUM_IRQ = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req,
    input  logic [XLEN-1:0] bits,
    output logic [XLEN-1:0] mask_q,
    output logic            done_q,
    output logic            ok_q
);
    import irq_sel_pkg::*;

    localparam logic [63:0]     ONES64 = low_ones(NUM_IRQ);
    localparam logic [XLEN-1:0] IMPL   = ONES64[XLEN-1:0];

    logic [XLEN-1:0] want;
    logic            clash;

    assign want  = bits & IMPL;
    assign clash = |(mask_q & want);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            done_q <= 1'b0;
            ok_q   <= 1'b0;
        end else begin
            done_q <= req;
            if (req) begin
                ok_q <= ~clash;
                if (!clash) mask_q <= mask_q | want;
            end
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int XLEN = 32,
    parameter int CW   = $clog2(XLEN)
) (
    input  logic            [XLEN-1:0] pend,
    input  logic            [XLEN-1:0] enable,
    input  logic            [XLEN-1:0] deleg,
    input  irq_sel_pkg::priv_e         priv,
    input  logic                       mie,
    input  logic                       sie,
    output logic                       hit,
    output logic            [CW-1:0]   idx
);
    import irq_sel_pkg::*;

    logic            m_ok;
    logic            s_ok;
    logic [XLEN-1:0] allow;

    assign m_ok = mach_gate(priv, mie);
    assign s_ok = sup_gate(priv, sie);

    for (genvar g = 0; g < XLEN; g++) begin : g_line
        assign allow[g] = pend[g] & enable[g] & (deleg[g] ? s_ok : m_ok);
    end

    // Scan from the top down so the lowest set bit is the last to win.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = XLEN - 1; i >= 0; i--) begin
            if (allow[i]) begin
                hit = 1'b1;
                idx = CW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_select.sv
module irq_select #(
    parameter int XLEN    = 32,
    parameter int NUM_IRQ = 16,
    parameter int CW      = $clog2(XLEN)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pend_wr_en,
    input  logic [XLEN-1:0] pend_wr_mask,
    input  logic [XLEN-1:0] pend_wr_data,
    output logic [XLEN-1:0] pend_old,
    input  logic [XLEN-1:0] enable_i,
    input  logic [XLEN-1:0] deleg_i,
    input  logic [1:0]      priv_i,
    input  logic            mie_i,
    input  logic            sie_i,
    input  logic            claim_en,
    input  logic [XLEN-1:0] claim_bits,
    output logic [XLEN-1:0] claim_mask,
    output logic            claim_done,
    output logic            claim_ok,
    output logic            irq_req,
    output logic            irq_valid,
    output logic [CW-1:0]   irq_cause
);
    import irq_sel_pkg::*;

    typedef struct packed {
        logic          valid;
        logic [CW-1:0] cause;
    } pick_t;

    logic [XLEN-1:0] pend_q;
    pick_t           pick_d;
    pick_t           pick_q;

    irq_pend_reg #(.XLEN(XLEN), .NUM_IRQ(NUM_IRQ)) u_pend (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (pend_wr_en),
        .wr_mask (pend_wr_mask),
        .wr_data (pend_wr_data),
        .pend_q  (pend_q)
    );

    irq_claim_reg #(.XLEN(XLEN), .NUM_IRQ(NUM_IRQ)) u_claim (
        .clk    (clk),
        .rst    (rst),
        .req    (claim_en),
        .bits   (claim_bits),
        .mask_q (claim_mask),
        .done_q (claim_done),
        .ok_q   (claim_ok)
    );

    irq_arbiter #(.XLEN(XLEN), .CW(CW)) u_arb (
        .pend   (pend_q),
        .enable (enable_i),
        .deleg  (deleg_i),
        .priv   (priv_e'(priv_i)),
        .mie    (mie_i),
        .sie    (sie_i),
        .hit    (pick_d.valid),
        .idx    (pick_d.cause)
    );

    always_ff @(posedge clk) begin
        if (rst) pick_q <= '0;
        else     pick_q <= pick_d;
    end

    assign pend_old  = pend_q;
    assign irq_req   = |pend_q;
    assign irq_valid = pick_q.valid;
    assign irq_cause = pick_q.cause;
endmodule

// File: rtl/irq_select_chk.sv
module irq_select_chk #(
    parameter int XLEN    = 32,
    parameter int NUM_IRQ = 16,
    parameter int CW      = $clog2(XLEN)
) (
    input logic            clk,
    input logic            rst,
    input logic            pend_wr_en,
    input logic [XLEN-1:0] pend_wr_mask,
    input logic [XLEN-1:0] pend_wr_data,
    input logic [XLEN-1:0] pend_old,
    input logic [XLEN-1:0] enable_i,
    input logic [XLEN-1:0] deleg_i,
    input logic [1:0]      priv_i,
    input logic            mie_i,
    input logic [XLEN-1:0] claim_mask,
    input logic            claim_done,
    input logic            claim_ok,
    input logic            irq_req,
    input logic            irq_valid,
    input logic [CW-1:0]   irq_cause
);
    import irq_sel_pkg::*;

    localparam logic [63:0]     ONES64 = low_ones(NUM_IRQ);
    localparam logic [XLEN-1:0] IMPL   = ONES64[XLEN-1:0];

    // R2
    masked_keep_chk: assert property (@(posedge clk) disable iff (rst)
        pend_wr_en |=> ((pend_old & ~$past(pend_wr_mask)) ==
                        ($past(pend_old) & ~$past(pend_wr_mask))));

    // R2
    masked_load_chk: assert property (@(posedge clk) disable iff (rst)
        pend_wr_en |=> ((pend_old & $past(pend_wr_mask)) ==
                        ($past(pend_wr_data) & $past(pend_wr_mask) & IMPL)));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !pend_wr_en |=> $stable(pend_old));

    // R4
    req_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_wr_en && ((pend_wr_mask & IMPL) == IMPL) && ((pend_wr_data & IMPL) == '0))
        |=> !irq_req);

    // R9
    cause_source_chk: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> ((($past(pend_old) & $past(enable_i)) >> irq_cause) & XLEN'(1)) != '0);

    // R5
    mach_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_valid && ($past(priv_i) == 2'd3)) |-> $past(mie_i));

    // R6
    sup_at_m_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_valid && ($past(priv_i) == 2'd3)) |->
        ((($past(deleg_i) >> irq_cause) & XLEN'(1)) == '0));

    // R8
    idle_cause_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_valid |-> (irq_cause == '0));

    // R10
    claim_fail_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (claim_done && !claim_ok) |-> $stable(claim_mask));

    // R10
    claim_grow_chk: assert property (@(posedge clk) disable iff (rst)
        ((claim_mask & $past(claim_mask)) == $past(claim_mask)));
endmodule

bind irq_select irq_select_chk #(.XLEN(XLEN), .NUM_IRQ(NUM_IRQ), .CW(CW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .pend_wr_en   (pend_wr_en),
    .pend_wr_mask (pend_wr_mask),
    .pend_wr_data (pend_wr_data),
    .pend_old     (pend_old),
    .enable_i     (enable_i),
    .deleg_i      (deleg_i),
    .priv_i       (priv_i),
    .mie_i        (mie_i),
    .claim_mask   (claim_mask),
    .claim_done   (claim_done),
    .claim_ok     (claim_ok),
    .irq_req      (irq_req),
    .irq_valid    (irq_valid),
    .irq_cause    (irq_cause)
);

// File: tb/irq_select_test.sv
module irq_select_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we = 1'b0;
    logic [31:0] wmask = '0;
    logic [31:0] wdata = '0;
    logic [31:0] en = '0;
    logic [31:0] dg = '0;
    logic [1:0]  priv = 2'd3;
    logic        mie = 1'b0;
    logic        sie = 1'b0;
    logic        ce = 1'b0;
    logic [31:0] cbits = '0;

    logic [31:0] pend_old;
    logic [31:0] claim_mask;
    logic        claim_done;
    logic        claim_ok;
    logic        irq_req;
    logic        irq_valid;
    logic [4:0]  irq_cause;

    always #5 clk = ~clk;

    irq_select uut (
        .clk(clk), .rst(rst),
        .pend_wr_en(we), .pend_wr_mask(wmask), .pend_wr_data(wdata),
        .pend_old(pend_old),
        .enable_i(en), .deleg_i(dg), .priv_i(priv), .mie_i(mie), .sie_i(sie),
        .claim_en(ce), .claim_bits(cbits),
        .claim_mask(claim_mask), .claim_done(claim_done), .claim_ok(claim_ok),
        .irq_req(irq_req), .irq_valid(irq_valid), .irq_cause(irq_cause)
    );

    typedef struct {
        logic [31:0] pend;
        logic        valid;
        logic [4:0]  cause;
        logic        cdone;
        logic        cok;
        logic [31:0] cmask;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          checks = 0;
    int          fails = 0;
    logic [31:0] m_pend = '0;
    logic [31:0] m_claim = '0;
    logic        prev_valid = 1'b0;
    bit          finished = 1'b0;

    localparam logic [31:0] LOW = 32'h0000_FFFF;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: inputs were set at a falling edge; compute what the next edge must show.
    task automatic go(input string tag);
        exp_t        e;
        logic [31:0] allow;
        logic        m_ok;
        logic        s_ok;
        bit          cok;
        #1;
        if (we) chk(pend_old == m_pend, "R3", pend_old, m_pend);
        chk(irq_valid == prev_valid, "R9", {31'b0, irq_valid}, {31'b0, prev_valid});
        m_ok  = (priv != 2'd3) || mie;
        s_ok  = (priv == 2'd0) || (priv == 2'd1 && sie);
        allow = (m_pend & en & ~dg & {32{m_ok}}) | (m_pend & en & dg & {32{s_ok}});
        e.valid = 1'b0;
        e.cause = '0;
        for (int i = 31; i >= 0; i--) begin
            if (allow[i]) begin
                e.valid = 1'b1;
                e.cause = 5'(i);
            end
        end
        cok = 1'b0;
        if (ce) begin
            cok = ((m_claim & cbits & LOW) == '0);
            if (cok) m_claim = m_claim | (cbits & LOW);
        end
        if (we) m_pend = ((m_pend & ~wmask) | (wdata & wmask)) & LOW;
        e.pend  = m_pend;
        e.cdone = ce;
        e.cok   = cok;
        e.cmask = m_claim;
        e.tag   = tag;
        sb.push_back(e);
        prev_valid = e.valid;
        @(negedge clk);
        we = 1'b0;
        ce = 1'b0;
    endtask

    // Monitor: compare just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                chk(pend_old == e.pend, "R2", pend_old, e.pend);
                chk(irq_req == (e.pend != 0), "R4", {31'b0, irq_req}, {31'b0, e.pend != 0});
                chk(irq_valid == e.valid, e.tag, {31'b0, irq_valid}, {31'b0, e.valid});
                chk(irq_cause == e.cause, e.tag, {27'b0, irq_cause}, {27'b0, e.cause});
                chk(claim_done == e.cdone, "R10", {31'b0, claim_done}, {31'b0, e.cdone});
                if (e.cdone) chk(claim_ok == e.cok, "R10", {31'b0, claim_ok}, {31'b0, e.cok});
                chk(claim_mask == e.cmask, "R10", claim_mask, e.cmask);
            end
        end
    end

    initial begin
        #2000000;
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // R1: a write held during reset must not land
        we = 1'b1; wmask = '1; wdata = '1; en = '1; mie = 1'b1;
        repeat (3) @(negedge clk);
        chk(pend_old == 0, "R1", pend_old, 0);
        chk(irq_req == 0, "R1", {31'b0, irq_req}, 0);
        chk(irq_valid == 0, "R1", {31'b0, irq_valid}, 0);
        chk(irq_cause == 0, "R1", {27'b0, irq_cause}, 0);
        chk(claim_mask == 0, "R1", claim_mask, 0);
        chk(claim_done == 0, "R1", {31'b0, claim_done}, 0);
        we = 1'b0; en = '0; mie = 1'b0;
        rst = 1'b0;
        go("R1");

        we = 1'b1; wmask = 32'hFFFF_FFFF; wdata = 32'hFFFF_FFFF; go("R2");
        we = 1'b1; wmask = 32'h0000_00F0; wdata = 32'h0; go("R8");
        en = 32'h0000_0800; priv = 2'd3; mie = 1'b0; go("R5");
        mie = 1'b1; go("R5");
        priv = 2'd1; mie = 1'b0; go("R5");
        priv = 2'd2; go("R5");
        dg = 32'h0000_0800; priv = 2'd1; sie = 1'b0; go("R6");
        sie = 1'b1; go("R6");
        priv = 2'd0; sie = 1'b0; go("R6");
        priv = 2'd3; mie = 1'b1; sie = 1'b1; go("R6");
        dg = '0; en = 32'h0000_FF00; go("R7");
        dg = 32'h0000_0100; go("R7");
        en = 32'h0000_000C; priv = 2'd0; go("R7");
        en = '0; go("R8");
        ce = 1'b1; cbits = 32'h0000_0003; go("R10");
        ce = 1'b1; cbits = 32'h0000_0006; go("R10");
        ce = 1'b1; cbits = 32'h0000_0004; go("R10");
        ce = 1'b1; cbits = 32'h0001_0000; go("R10");
        we = 1'b1; wmask = 32'h0; wdata = 32'hFFFF_FFFF; go("R2");
        en = 32'h0000_FFFF; we = 1'b1; wmask = 32'h0000_FFFF; wdata = 32'h0; go("R4");
        go("R4");
        go("R8");
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule